// File: doc/BRIEF.md
# Alternating Threshold Register Loader

This block holds the two 12-bit thresholds that a FIFO's programmable flag logic compares against. One threshold sets how close to empty the FIFO must be before the almost-empty flag asserts. The other sets the same distance for the almost-full flag. There is no address input. While load mode is active, every write-side access stores the low data bits into one threshold register, and every read-side access copies one threshold onto the data output. An internal selector picks the register and flips after each access. The sequence therefore runs empty, full, empty, and so on, on each side.

The selector keeps its position when load mode is left and entered again. A session may program just one register, return to normal traffic, and later continue with the other one. The write side and the read side each have their own selector, clocked by their own clock, and neither one moves the other. While load mode is active, the block suppresses the FIFO write and read strobes so that threshold accesses never touch the storage array. After reset, both thresholds take a default that depends on the FIFO depth.

Top module: `ofs_loader`

## Requirements
- R1: While `rst_i` is high, at a rising edge of both clocks, both thresholds take the depth default. The default is 0x01F for a depth of at most 256, 0x03F for a depth of at most 512, and 0x07F otherwise; it is 0x07F for the default depth of 1024. The same reset clears `rd_data_o` to zero and points both selectors at the empty threshold.
- R2: With `load_i`=1 and `wr_en_i`=1, a rising `clk_wr_i` edge stores `ofs_wdata_i` into the threshold that the write selector points at, then flips the selector. After reset, successive stores land in the empty threshold, then the full threshold, then the empty threshold again.
- R3: With `load_i`=1 and `wr_en_i`=0, a write-clock edge changes neither threshold and leaves the write selector where it was.
- R4: With `load_i`=0, a write-clock edge leaves both thresholds unchanged. `fifo_wr_o` is high exactly when `wr_en_i`=1 and `load_i`=0.
- R5: Leaving load mode and entering it again keeps the write selector's position. The next store goes to the register after the last one written.
- R6: With `load_i`=1 and `rd_en_i`=1, a rising `clk_rd_i` edge loads `rd_data_o` with the threshold that the read selector points at, then flips the read selector. After reset, reads start with the empty threshold and alternate.
- R7: At a read-clock edge without `load_i`=1 and `rd_en_i`=1 together, `rd_data_o` keeps its value.
- R8: The read selector moves only on read-side accesses. Its position does not depend on how many stores the write side has made.
- R9: `fifo_rd_o` is high exactly when `rd_en_i`=1 and `load_i`=0.
- R10: Bits of `rd_data_o` above bit 11 are always zero. Bits 11:0 carry the threshold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_wr_i | input | 1 | Write-side clock |
| clk_rd_i | input | 1 | Read-side clock |
| rst_i | input | 1 | Synchronous active-high reset, held across edges of both clocks |
| load_i | input | 1 | Load mode: accesses target the thresholds instead of the FIFO |
| wr_en_i | input | 1 | Write enable |
| ofs_wdata_i | input | 12 | Low data bits stored into a threshold |
| rd_en_i | input | 1 | Read enable |
| rd_data_o | output | DATA_W (18) | Threshold read-back word, zero-extended |
| fifo_wr_o | output | 1 | Gated FIFO write strobe |
| fifo_rd_o | output | 1 | Gated FIFO read strobe |
| empty_ofs_o | output | 12 | Current almost-empty threshold |
| full_ofs_o | output | 12 | Current almost-full threshold |

## Verification
The read-back assertion compares the new output against the threshold values one read-clock edge earlier. This assumes that the thresholds do not change between write-clock and read-clock edges in a way that the sampling would miss. The bench meets that assumption by driving both clock inputs from the same clock. The properties also assume that reset is held across edges of both clocks. All inputs change only on falling edges, so every rising edge sees stable levels for load, the enables and the data.

// File: rtl/ofs_loader_pkg.sv
`timescale 1ns/1ps
package ofs_loader_pkg;

    localparam int OFS_WIDTH = 12;

    typedef logic [OFS_WIDTH-1:0] ofs_word_t;

    // Which threshold the next access targets.
    typedef enum logic {
        SEL_EMPTY = 1'b0,
        SEL_FULL  = 1'b1
    } ofs_sel_e;

    // Kind of access an enable performs in a given mode.
    typedef enum logic [1:0] {
        ACC_NONE   = 2'd0,
        ACC_FIFO   = 2'd1,
        ACC_OFFSET = 2'd2
    } acc_kind_e;

    typedef struct packed {
        ofs_word_t empty_ofs;
        ofs_word_t full_ofs;
    } ofs_pair_t;

    function automatic acc_kind_e decode_access(input logic load, input logic en);
        if (!en)
            return ACC_NONE;
        else if (load)
            return ACC_OFFSET;
        else
            return ACC_FIFO;
    endfunction

    function automatic int unsigned default_offset(input int unsigned depth);
        if (depth <= 256)
            return 32'h0000_001F;
        else if (depth <= 512)
            return 32'h0000_003F;
        else
            return 32'h0000_007F;
    endfunction

    function automatic ofs_sel_e next_sel(input ofs_sel_e cur);
        return (cur == SEL_EMPTY) ? SEL_FULL : SEL_EMPTY;
    endfunction

endpackage

// File: rtl/ofs_access_decode.sv
`timescale 1ns/1ps
module ofs_access_decode
    import ofs_loader_pkg::*;
(
    input  logic load_i,
    input  logic en_i,
    output logic ofs_go_o,
    output logic fifo_go_o
);

    acc_kind_e kind;

    always_comb begin
        kind      = decode_access(load_i, en_i);
        ofs_go_o  = (kind == ACC_OFFSET);
        fifo_go_o = (kind == ACC_FIFO);
    end

endmodule

// File: rtl/ofs_selector.sv
`timescale 1ns/1ps
module ofs_selector
    import ofs_loader_pkg::*;
(
    input  logic     clk_i,
    input  logic     rst_i,
    input  logic     adv_i,
    output ofs_sel_e sel_o
);

    ofs_sel_e sel_q;

    always_ff @(posedge clk_i) begin
        if (rst_i)
            sel_q <= SEL_EMPTY;
        else if (adv_i)
            sel_q <= next_sel(sel_q);
    end

    assign sel_o = sel_q;

endmodule

// File: rtl/ofs_regfile.sv
`timescale 1ns/1ps
module ofs_regfile
    import ofs_loader_pkg::*;
#(
    parameter int unsigned DEPTH = 1024
) (
    input  logic      clk_i,
    input  logic      rst_i,
    input  logic      we_i,
    input  ofs_sel_e  sel_i,
    input  ofs_word_t wdata_i,
    output ofs_pair_t regs_o
);

    localparam ofs_word_t RST_VAL = OFS_WIDTH'(default_offset(DEPTH));

    ofs_pair_t regs_q;

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            regs_q.empty_ofs <= RST_VAL;
            regs_q.full_ofs  <= RST_VAL;
        end else if (we_i) begin
            if (sel_i == SEL_EMPTY)
                regs_q.empty_ofs <= wdata_i;
            else
                regs_q.full_ofs  <= wdata_i;
        end
    end

    assign regs_o = regs_q;

endmodule

// File: rtl/ofs_readback.sv
`timescale 1ns/1ps
module ofs_readback
    import ofs_loader_pkg::*;
#(
    parameter int DATA_W = 18
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              go_i,
    input  ofs_sel_e          sel_i,
    input  ofs_pair_t         regs_i,
    output logic [DATA_W-1:0] rdata_o
);

    ofs_word_t         pick;
    logic [DATA_W-1:0] rdata_q;

    always_comb begin
        pick = (sel_i == SEL_EMPTY) ? regs_i.empty_ofs : regs_i.full_ofs;
    end

    always_ff @(posedge clk_i) begin
        if (rst_i)
            rdata_q <= '0;
        else if (go_i)
            rdata_q <= DATA_W'(pick);
    end

    assign rdata_o = rdata_q;

endmodule

// File: rtl/ofs_loader.sv
`timescale 1ns/1ps
module ofs_loader
    import ofs_loader_pkg::*;
#(
    parameter int unsigned DEPTH  = 1024,
    parameter int          DATA_W = 18
) (
    input  logic                 clk_wr_i,
    input  logic                 clk_rd_i,
    input  logic                 rst_i,
    input  logic                 load_i,
    input  logic                 wr_en_i,
    input  logic [OFS_WIDTH-1:0] ofs_wdata_i,
    input  logic                 rd_en_i,
    output logic [DATA_W-1:0]    rd_data_o,
    output logic                 fifo_wr_o,
    output logic                 fifo_rd_o,
    output logic [OFS_WIDTH-1:0] empty_ofs_o,
    output logic [OFS_WIDTH-1:0] full_ofs_o
);

    logic      wr_ofs_go;
    logic      rd_ofs_go;
    ofs_sel_e  wr_sel;
    ofs_sel_e  rd_sel;
    ofs_pair_t regs;

    // Write side: decode, selector, storage.
    ofs_access_decode u_wr_dec (
        .load_i    (load_i),
        .en_i      (wr_en_i),
        .ofs_go_o  (wr_ofs_go),
        .fifo_go_o (fifo_wr_o)
    );

    ofs_selector u_wr_sel (
        .clk_i (clk_wr_i),
        .rst_i (rst_i),
        .adv_i (wr_ofs_go),
        .sel_o (wr_sel)
    );

    ofs_regfile #(.DEPTH(DEPTH)) u_regs (
        .clk_i   (clk_wr_i),
        .rst_i   (rst_i),
        .we_i    (wr_ofs_go),
        .sel_i   (wr_sel),
        .wdata_i (ofs_wdata_i),
        .regs_o  (regs)
    );

    // Read side: decode, its own selector, output register.
    ofs_access_decode u_rd_dec (
        .load_i    (load_i),
        .en_i      (rd_en_i),
        .ofs_go_o  (rd_ofs_go),
        .fifo_go_o (fifo_rd_o)
    );

    ofs_selector u_rd_sel (
        .clk_i (clk_rd_i),
        .rst_i (rst_i),
        .adv_i (rd_ofs_go),
        .sel_o (rd_sel)
    );

    ofs_readback #(.DATA_W(DATA_W)) u_rb (
        .clk_i   (clk_rd_i),
        .rst_i   (rst_i),
        .go_i    (rd_ofs_go),
        .sel_i   (rd_sel),
        .regs_i  (regs),
        .rdata_o (rd_data_o)
    );

    assign empty_ofs_o = regs.empty_ofs;
    assign full_ofs_o  = regs.full_ofs;

endmodule

// File: rtl/ofs_loader_chk.sv
`timescale 1ns/1ps
module ofs_loader_chk
    import ofs_loader_pkg::*;
#(
    parameter int DATA_W = 18
) (
    input logic                 clk_wr_i,
    input logic                 clk_rd_i,
    input logic                 rst_i,
    input logic                 load_i,
    input logic                 wr_en_i,
    input logic [OFS_WIDTH-1:0] ofs_wdata_i,
    input logic                 rd_en_i,
    input logic [DATA_W-1:0]    rd_data_o,
    input logic [OFS_WIDTH-1:0] empty_ofs_o,
    input logic [OFS_WIDTH-1:0] full_ofs_o
);

    // R2
    store_lands_chk: assert property (@(posedge clk_wr_i) disable iff (rst_i)
        (load_i && wr_en_i) |=> ((empty_ofs_o == $past(ofs_wdata_i)) ||
                                 (full_ofs_o  == $past(ofs_wdata_i))));

    // R3
    idle_load_hold_chk: assert property (@(posedge clk_wr_i) disable iff (rst_i)
        (load_i && !wr_en_i) |=> ($stable(empty_ofs_o) && $stable(full_ofs_o)));

    // R4
    normal_mode_hold_chk: assert property (@(posedge clk_wr_i) disable iff (rst_i)
        !load_i |=> ($stable(empty_ofs_o) && $stable(full_ofs_o)));

    // R6
    readback_src_chk: assert property (@(posedge clk_rd_i) disable iff (rst_i)
        (load_i && rd_en_i) |=> ((rd_data_o[OFS_WIDTH-1:0] == $past(empty_ofs_o)) ||
                                 (rd_data_o[OFS_WIDTH-1:0] == $past(full_ofs_o))));

    // R7
    readback_hold_chk: assert property (@(posedge clk_rd_i) disable iff (rst_i)
        !(load_i && rd_en_i) |=> $stable(rd_data_o));

    // R10
    upper_zero_chk: assert property (@(posedge clk_rd_i) disable iff (rst_i)
        (rd_data_o >> OFS_WIDTH) == '0);

endmodule

bind ofs_loader ofs_loader_chk #(.DATA_W(DATA_W)) u_chk (.*);

// File: tb/ofs_loader_test.sv
`timescale 1ns/1ps
module ofs_loader_test;

    localparam int DATA_W = 18;
    localparam logic [11:0] DEF = 12'h07F;

    logic              clk = 1'b0;
    logic              rst_i = 1'b1;
    logic              load_i = 1'b0;
    logic              wr_en_i = 1'b0;
    logic [11:0]       ofs_wdata_i = '0;
    logic              rd_en_i = 1'b0;
    logic [DATA_W-1:0] rd_data_o;
    logic              fifo_wr_o;
    logic              fifo_rd_o;
    logic [11:0]       empty_ofs_o;
    logic [11:0]       full_ofs_o;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;
    logic [DATA_W-1:0] expq[$];

    always #2.5 clk = ~clk;

    ofs_loader #(.DEPTH(1024), .DATA_W(DATA_W)) uut (
        .clk_wr_i    (clk),
        .clk_rd_i    (clk),
        .rst_i       (rst_i),
        .load_i      (load_i),
        .wr_en_i     (wr_en_i),
        .ofs_wdata_i (ofs_wdata_i),
        .rd_en_i     (rd_en_i),
        .rd_data_o   (rd_data_o),
        .fifo_wr_o   (fifo_wr_o),
        .fifo_rd_o   (fifo_rd_o),
        .empty_ofs_o (empty_ofs_o),
        .full_ofs_o  (full_ofs_o)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic store(input logic [11:0] d);
        load_i = 1'b1; wr_en_i = 1'b1; ofs_wdata_i = d;
        @(negedge clk);
        wr_en_i = 1'b0;
    endtask

    // Driver: pushes the expected read-back word, then issues the access.
    task automatic fetch(input logic [11:0] exp);
        expq.push_back(DATA_W'(exp));
        load_i = 1'b1; rd_en_i = 1'b1;
        @(negedge clk);
        rd_en_i = 1'b0;
    endtask

    // Monitor: each read-side access yields one word one edge later.
    always @(posedge clk) begin
        if (!rst_i && load_i && rd_en_i) begin
            @(negedge clk);
            if (expq.size() == 0) begin
                chk("R6 unexpected readback", 32'(rd_data_o), 32'hFFFF_FFFF);
            end else begin
                logic [DATA_W-1:0] e;
                e = expq.pop_front();
                // R6 R8 R10: full-width compare, upper bits expected zero
                chk("R6 readback word", 32'(rd_data_o), 32'(e));
            end
        end
    end

    initial begin
        #1000000;
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_i = 1'b0;
        // R1: defaults after reset
        chk("R1 empty default", 32'(empty_ofs_o), 32'(DEF));
        chk("R1 full default", 32'(full_ofs_o), 32'(DEF));
        chk("R1 readback cleared", 32'(rd_data_o), 32'h0);

        // R2: alternating stores
        store(12'hABC);
        chk("R2 first store empty", 32'(empty_ofs_o), 32'hABC);
        chk("R2 full untouched", 32'(full_ofs_o), 32'(DEF));
        store(12'h123);
        chk("R2 second store full", 32'(full_ofs_o), 32'h123);
        store(12'h456);
        chk("R2 third store empty", 32'(empty_ofs_o), 32'h456);
        chk("R2 full kept", 32'(full_ofs_o), 32'h123);

        // R3: load without enable changes nothing, selector holds
        load_i = 1'b1; wr_en_i = 1'b0; ofs_wdata_i = 12'hF0F;
        repeat (2) @(negedge clk);
        chk("R3 empty held", 32'(empty_ofs_o), 32'h456);
        chk("R3 full held", 32'(full_ofs_o), 32'h123);
        store(12'h777);
        chk("R3 selector held, store to full", 32'(full_ofs_o), 32'h777);

        // R4: normal write strobes FIFO and leaves thresholds
        chk("R4 no fifo write while loading", 32'(fifo_wr_o), 32'h0);
        load_i = 1'b1; wr_en_i = 1'b1; #0.1;
        chk("R4 fifo write gated in load", 32'(fifo_wr_o), 32'h0);
        load_i = 1'b0; ofs_wdata_i = 12'h999; #0.1;
        chk("R4 fifo write strobe", 32'(fifo_wr_o), 32'h1);
        @(negedge clk);
        wr_en_i = 1'b0;
        chk("R4 empty unchanged", 32'(empty_ofs_o), 32'h456);
        chk("R4 full unchanged", 32'(full_ofs_o), 32'h777);

        // R5: partial session, leave, resume
        store(12'h111);
        load_i = 1'b0;
        repeat (3) @(negedge clk);
        store(12'h222);
        chk("R5 resume targets full", 32'(full_ofs_o), 32'h222);
        chk("R5 empty from session", 32'(empty_ofs_o), 32'h111);
        store(12'h333); // write selector now points at full

        // R6 R8: reads start at empty regardless of write selector
        fetch(12'h333);
        fetch(12'h222);
        fetch(12'h333);

        // R7 R9: no readback without both load and read enable
        load_i = 1'b1; rd_en_i = 1'b0;
        repeat (2) @(negedge clk);
        chk("R7 hold in load idle", 32'(rd_data_o), 32'h333);
        chk("R9 fifo read gated in load", 32'(fifo_rd_o), 32'h0);
        load_i = 1'b0; rd_en_i = 1'b1; #0.1;
        chk("R9 fifo read strobe", 32'(fifo_rd_o), 32'h1);
        @(negedge clk);
        rd_en_i = 1'b0;
        chk("R7 hold in normal read", 32'(rd_data_o), 32'h333);
        chk("R10 upper bits zero", 32'(rd_data_o >> 12), 32'h0);
        fetch(12'h222); // read selector continues at full

        // R1: second reset restores defaults and both selectors
        load_i = 1'b0;
        rst_i = 1'b1;
        repeat (2) @(negedge clk);
        rst_i = 1'b0;
        chk("R1 empty default again", 32'(empty_ofs_o), 32'(DEF));
        chk("R1 full default again", 32'(full_ofs_o), 32'(DEF));
        chk("R1 readback cleared again", 32'(rd_data_o), 32'h0);
        store(12'h0AA);
        chk("R1 write selector reset", 32'(empty_ofs_o), 32'h0AA);
        fetch(12'h0AA);
        load_i = 1'b0;
        repeat (2) @(negedge clk);
        chk("R6 queue drained", 32'(expq.size()), 32'h0);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule